// File: doc/BRIEF.md
# Double-Buffered Pulse-Width Modulator

This block generates a single pulse-width modulated output from an 8-bit period timer with a selectable prescaler. The PWM period is set by a period value. A 10-bit duty value sets the high time. The duty value is compared against the timer extended by two fine sub-count bits. A host loads the upper eight and the lower two duty bits through two separate write strobes into a pending register. The comparator never sees the pending register directly. It uses an active (shadow) copy, which is refreshed only when a period starts. A duty write can therefore arrive in any cycle without cutting a pulse short or producing a runt pulse.

The output phase is a three-state machine. `PH_OFF` is held while the enable is low. The **start** transition (enable seen high in `PH_OFF`) and the **wrap** transition (timer rollover) both copy the pending duty into the shadow. They enter `PH_HIGH` when that duty is non-zero and `PH_LOW` when it is zero. The **match** transition takes `PH_HIGH` to `PH_LOW` once the fine position reaches the active duty. The **disable** transition returns every state to `PH_OFF` and clears the timer and prescaler.

Top module: `pwm_dbuf`

## Requirements
- R1: While reset is asserted and after it is released with the enable low, `pwm_o` is 0.
- R2: `duty_hi_we_i` loads `duty_hi_i` into bits 9..2 of the pending duty and `duty_lo_we_i` loads `duty_lo_i` into bits 1..0. Each strobe leaves the other field unchanged.
- R3: A pending-duty write made during a period does not change that period's high time. It takes effect from the next period on.
- R4: With prescale divide 1, a period lasts 4*(period_i+1) clocks. The output is high for the first `duty` clocks of each period and low for the rest.
- R5: `presc_i` selects the divide: 0 gives 1, 1 gives 4, 2 and 3 give 16. A period lasts 4*P*(period_i+1) clocks and the high time is duty*P clocks.
- R6: A duty of 0 keeps `pwm_o` low for the entire period.
- R7: A duty of 4*(period_i+1) or more never matches, so `pwm_o` stays high for the entire period. A duty of 4*(period_i+1)-1 still produces one low sub-step.
- R8: In the cycle after `en_i` is sampled low, `pwm_o` is 0 and the timer and prescaler are cleared. In the cycle after `en_i` is sampled high from the disabled state, a fresh period starts at position 0 with the pending duty.
- R9: The timer wraps to 0 on the increment at which it is at or above `period_i`. The output rises only in a cycle that follows a start or wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| presc_i | input | 2 | Prescale select (0: /1, 1: /4, 2-3: /16) |
| period_i | input | 8 | Period value; period is period_i+1 timer steps |
| duty_hi_we_i | input | 1 | Write strobe for the upper duty field |
| duty_hi_i | input | 8 | Upper eight duty bits |
| duty_lo_we_i | input | 1 | Write strobe for the lower duty field |
| duty_lo_i | input | 2 | Lower two duty bits |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the block with its default widths: an 8-bit timer, 2 sub-count bits and a 6-bit prescale counter. These widths bring every prescale setting within reach, along with the full 0xFF period at 10-bit resolution. With short periods such as 3 and 7, the zero, full-scale and one-below-full-scale duty corners and the rollover each take only tens of cycles. Mid-period writes are scheduled at known cycles so that the bench can show, period by period, when each field change reaches the output.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    // Output phase of the modulator
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } pwm_phase_e;

    // Largest prescale shift (divide 16 = 2^4)
    localparam int unsigned PSC_MAX_SHIFT = 4;

    // Prescale select to log2 of the divide ratio
    function automatic logic [2:0] presc_shift(input logic [1:0] sel);
        unique case (sel)
            2'd0:    presc_shift = 3'd0;
            2'd1:    presc_shift = 3'd2;
            default: presc_shift = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pwm_dbuf_prescaler.sv
module pwm_dbuf_prescaler
    import pwm_dbuf_pkg::*;
#(
    parameter int unsigned SUB_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [1:0]       sel_i,
    output logic             tick_o,
    output logic [SUB_W-1:0] sub_nxt_o
);
    localparam int unsigned CNT_W = SUB_W + PSC_MAX_SHIFT;

    logic [CNT_W-1:0] cnt_q, cnt_d, lim;
    logic [CNT_W:0]   lim_w;
    logic [2:0]       shamt;

    always_comb begin
        shamt  = presc_shift(sel_i);
        lim_w  = ({{CNT_W{1'b0}}, 1'b1} << (SUB_W + shamt)) - 1'b1;
        lim    = lim_w[CNT_W-1:0];
        tick_o = (cnt_q >= lim);
        if (clr_i)      cnt_d = '0;
        else if (run_i) cnt_d = tick_o ? '0 : cnt_q + 1'b1;
        else            cnt_d = cnt_q;
        sub_nxt_o = SUB_W'(cnt_d >> shamt);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // R8: a disable clears the prescale counter
    assert_pre_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_dbuf_timebase.sv
module pwm_dbuf_timebase #(
    parameter int unsigned TMR_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic [TMR_W-1:0] period_i,
    output logic [TMR_W-1:0] timer_nxt_o,
    output logic             wrap_o
);
    logic [TMR_W-1:0] timer_q;

    always_comb begin
        wrap_o = step_i && (timer_q >= period_i);
        if (clr_i)       timer_nxt_o = '0;
        else if (wrap_o) timer_nxt_o = '0;
        else if (step_i) timer_nxt_o = timer_q + 1'b1;
        else             timer_nxt_o = timer_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) timer_q <= '0;
        else         timer_q <= timer_nxt_o;
    end

    // R9: a rollover returns the timer to zero
    assert_wrap_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (timer_q == '0));

    // R8: a disable clears the timer
    assert_timer_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (timer_q == '0));

endmodule

// File: rtl/pwm_dbuf_shadow.sv
module pwm_dbuf_shadow #(
    parameter int unsigned TMR_W = 8,
    parameter int unsigned SUB_W = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   hi_we_i,
    input  logic [TMR_W-1:0]       hi_i,
    input  logic                   lo_we_i,
    input  logic [SUB_W-1:0]       lo_i,
    input  logic                   load_i,
    output logic                   pend_zero_o,
    output logic [TMR_W+SUB_W-1:0] act_o
);
    localparam int unsigned DUTY_W = TMR_W + SUB_W;

    logic [DUTY_W-1:0] pend_q, act_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= '0;
        end else begin
            if (hi_we_i) pend_q[DUTY_W-1:SUB_W] <= hi_i;
            if (lo_we_i) pend_q[SUB_W-1:0]      <= lo_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     act_q <= '0;
        else if (load_i) act_q <= pend_q;
    end

    assign pend_zero_o = (pend_q == '0);
    assign act_o       = act_q;

    // R3: the active duty moves only at a period start
    assert_shadow_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(act_q));

    // R2: a low-field write leaves the high field alone
    assert_lo_field_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lo_we_i && !hi_we_i) |=> (pend_q[DUTY_W-1:SUB_W] == $past(pend_q[DUTY_W-1:SUB_W])));

    // R2: a high-field write leaves the low field alone
    assert_hi_field_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hi_we_i && !lo_we_i) |=> (pend_q[SUB_W-1:0] == $past(pend_q[SUB_W-1:0])));

endmodule

// File: rtl/pwm_dbuf_fsm.sv
module pwm_dbuf_fsm
    import pwm_dbuf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic wrap_i,
    input  logic pend_zero_i,
    input  logic match_i,
    output logic load_o,
    output logic run_o,
    output logic pwm_o
);
    pwm_phase_e st_q, st_d;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_OFF: begin
                if (en_i) st_d = pend_zero_i ? PH_LOW : PH_HIGH;      // start
            end
            PH_HIGH: begin
                if (!en_i)       st_d = PH_OFF;                       // disable
                else if (wrap_i) st_d = pend_zero_i ? PH_LOW : PH_HIGH; // wrap
                else if (match_i) st_d = PH_LOW;                      // match
            end
            PH_LOW: begin
                if (!en_i)       st_d = PH_OFF;                       // disable
                else if (wrap_i) st_d = pend_zero_i ? PH_LOW : PH_HIGH; // wrap
            end
            default: st_d = PH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= PH_OFF;
        else         st_q <= st_d;
    end

    // outputs
    always_comb begin
        run_o  = en_i && (st_q != PH_OFF);
        load_o = en_i && ((st_q == PH_OFF) || wrap_i);
        pwm_o  = (st_q == PH_HIGH);
    end

    // R8: output low once disable is sampled
    assert_off_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !pwm_o);

    // R6: a zero duty loaded at a period start gives a low output
    assert_zero_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_o && pend_zero_i) |=> !pwm_o);

    // R9: the output rises only after a start or wrap
    assert_rise_after_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pwm_o) |-> $past(load_o));

endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf #(
    parameter int unsigned TMR_W = 8,
    parameter int unsigned SUB_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [1:0]       presc_i,
    input  logic [TMR_W-1:0] period_i,
    input  logic             duty_hi_we_i,
    input  logic [TMR_W-1:0] duty_hi_i,
    input  logic             duty_lo_we_i,
    input  logic [SUB_W-1:0] duty_lo_i,
    output logic             pwm_o
);
    localparam int unsigned DUTY_W = TMR_W + SUB_W;

    logic              run, load, tick, wrap, pend_zero, match;
    logic [SUB_W-1:0]  sub_nxt;
    logic [TMR_W-1:0]  timer_nxt;
    logic [DUTY_W-1:0] act_duty;

    pwm_dbuf_prescaler #(.SUB_W(SUB_W)) u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (!en_i),
        .run_i     (run),
        .sel_i     (presc_i),
        .tick_o    (tick),
        .sub_nxt_o (sub_nxt)
    );

    pwm_dbuf_timebase #(.TMR_W(TMR_W)) u_tbase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .clr_i       (!en_i),
        .step_i      (run && tick),
        .period_i    (period_i),
        .timer_nxt_o (timer_nxt),
        .wrap_o      (wrap)
    );

    pwm_dbuf_shadow #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_shadow (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hi_we_i     (duty_hi_we_i),
        .hi_i        (duty_hi_i),
        .lo_we_i     (duty_lo_we_i),
        .lo_i        (duty_lo_i),
        .load_i      (load),
        .pend_zero_o (pend_zero),
        .act_o       (act_duty)
    );

    // compare against the fine position the counters move to next
    assign match = ({timer_nxt, sub_nxt} == act_duty);

    pwm_dbuf_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .wrap_i      (wrap),
        .pend_zero_i (pend_zero),
        .match_i     (match),
        .load_o      (load),
        .run_o       (run),
        .pwm_o       (pwm_o)
    );

    // R1: output low while reset is held
    always_comb begin
        if (!rst_ni) assert_reset_low_R1: assert (pwm_o == 1'b0);
    end

endmodule

// File: tb/pwm_dbuf_bench.sv
module pwm_dbuf_bench;

    typedef struct {
        int    high;
        int    len;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       en_i = 1'b0;
    logic [1:0] presc_i = '0;
    logic [7:0] period_i = '0;
    logic       duty_hi_we_i = 1'b0;
    logic [7:0] duty_hi_i = '0;
    logic       duty_lo_we_i = 1'b0;
    logic [1:0] duty_lo_i = '0;
    logic       pwm_o;

    int    total = 0;
    int    bad = 0;
    bit    busy = 1'b0;
    item_t sb[$];

    always #2.5 clk = ~clk;  // 200 MHz

    pwm_dbuf u_pwm_dbuf (
        .clk_i        (clk),
        .rst_ni       (rst_ni),
        .en_i         (en_i),
        .presc_i      (presc_i),
        .period_i     (period_i),
        .duty_hi_we_i (duty_hi_we_i),
        .duty_hi_i    (duty_hi_i),
        .duty_lo_we_i (duty_lo_we_i),
        .duty_lo_i    (duty_lo_i),
        .pwm_o        (pwm_o)
    );

    function automatic int div_of(input int code);
        return (code == 0) ? 1 : (code == 1) ? 4 : 16;
    endfunction

    function automatic item_t expect_item(input int code, input int per, input int duty, input string tag);
        item_t it;
        int    p = div_of(code);
        it.len = 4 * p * (per + 1);
        if (duty == 0)                 it.high = 0;
        else if (duty >= 4 * (per + 1)) it.high = it.len;
        else                           it.high = duty * p;
        it.tag = tag;
        return it;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_duty(input int hi, input int lo, input bit whi, input bit wlo);
        @(negedge clk);
        duty_hi_i    = 8'(hi);
        duty_lo_i    = 2'(lo);
        duty_hi_we_i = whi;
        duty_lo_we_i = wlo;
        @(negedge clk);
        duty_hi_we_i = 1'b0;
        duty_lo_we_i = 1'b0;
    endtask

    task automatic finish_run();
        wait (sb.size() == 0 && !busy);
        @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        check(pwm_o == 1'b0, "R8 low after disable", int'(pwm_o), 0);
    endtask

    // configure while disabled, enable, and push n identical periods
    task automatic run_case(input int code, input int per, input int duty, input int n, input string tag);
        presc_i  = 2'(code);
        period_i = 8'(per);
        write_duty(duty >> 2, duty & 3, 1'b1, 1'b1);
        @(negedge clk);
        en_i = 1'b1;
        for (int i = 0; i < n; i++) sb.push_back(expect_item(code, per, duty, tag));
        finish_run();
    endtask

    // monitor: measure each period and compare with the queued item
    initial begin
        forever begin
            item_t it;
            int    hcnt;
            int    miss;
            wait (sb.size() > 0);
            it   = sb.pop_front();
            busy = 1'b1;
            hcnt = 0;
            miss = 0;
            for (int c = 0; c < it.len; c++) begin
                @(negedge clk);
                if (pwm_o) hcnt++;
                if (pwm_o != (c < it.high)) miss++;
            end
            total++;
            if (hcnt != it.high || miss != 0) begin
                bad++;
                $display("FAIL %s: high=%0d misplaced=%0d expected high=%0d of %0d",
                         it.tag, hcnt, miss, it.high, it.len);
            end
            busy = 1'b0;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b0, "R1 during reset", int'(pwm_o), 0);
        rst_ni = 1'b1;
        @(negedge clk);
        check(pwm_o == 1'b0, "R1 after reset", int'(pwm_o), 0);

        // R8: disabled with a non-zero duty stays low
        write_duty(2, 1, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(pwm_o == 1'b0, "R8 disabled stays low", int'(pwm_o), 0);
        end

        run_case(0, 3, 5,   2, "R4 div1 per3 duty5");
        run_case(0, 7, 13,  2, "R4 div1 per7 duty13");
        run_case(0, 3, 0,   2, "R6 zero duty");
        run_case(0, 3, 15,  2, "R7 one below full");
        run_case(0, 3, 16,  2, "R7 duty equals full");
        run_case(0, 3, 40,  1, "R7 duty above full");
        run_case(1, 2, 7,   2, "R5 div4");
        run_case(2, 1, 3,   2, "R5 div16 code2");
        run_case(3, 1, 6,   1, "R5 div16 code3");
        run_case(0, 255, 1023, 1, "R4 full 10-bit period");
        run_case(0, 0, 1,   3, "R9 period zero");

        // R3 and R2: writes in the middle of running periods
        presc_i  = 2'd0;
        period_i = 8'd7;
        write_duty(2, 2, 1'b1, 1'b1);                         // duty 10
        @(negedge clk);
        en_i = 1'b1;
        sb.push_back(expect_item(0, 7, 10, "R3 old duty holds"));
        sb.push_back(expect_item(0, 7, 20, "R3 new duty next period"));
        sb.push_back(expect_item(0, 7, 23, "R2 low field only"));
        sb.push_back(expect_item(0, 7, 11, "R2 high field only"));
        repeat (4) @(negedge clk);
        write_duty(5, 0, 1'b1, 1'b1);                         // duty 20 in period 1
        repeat (34) @(negedge clk);
        write_duty(0, 3, 1'b0, 1'b1);                         // low field only -> 23
        repeat (34) @(negedge clk);
        write_duty(2, 0, 1'b1, 1'b0);                         // high field only -> 11
        finish_run();

        // R8: re-enable restarts from position zero with the pending duty
        @(negedge clk);
        en_i = 1'b1;
        sb.push_back(expect_item(0, 7, 11, "R8 restart clean"));
        finish_run();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule